// File: doc/BRIEF.md
# DMA External Request Handshake Controller

This block runs the request, acknowledge and done handshake between an external requester and one DMA channel. The request pin may change at any time relative to the system clock, so it passes through a synchronizer before edge detection. When a rising request is accepted, the block sends a one-cycle start pulse to the transfer engine, which activates the channel. It then raises acknowledge and holds it while the engine moves data. When the engine reports the end of the transfer, acknowledge drops, and one clock later done rises. Done stays high until the next request is accepted.

When pause mode is enabled, a segment-finished report from the engine also drops acknowledge. The channel then waits, still busy and without raising done, until a new request resumes it. Acknowledge holds each of its levels for a minimum number of clocks. A request edge that arrives at a moment when it is not allowed sets a sticky error flag. Software clears that flag by writing a one.

Top module: `dma_xreq_handshake`

## Requirements
- R1: After reset, start_o, ack_o, done_o, busy_o and err_o are all 0.
- R2: A request that rises while ack_o is low is accepted. The input passes through two synchronizer flops, so start_o is high for exactly one clock in the third clock after the input rises, with ack_o still low. ack_o rises one clock later, provided its minimum low time has elapsed.
- R3: ack_o stays high for the whole transfer. A fall of the request while ack_o is high has no effect.
- R4: Each level of ack_o lasts at least MIN_W clocks (default 4). If xfer_done_i arrives d clocks after ack_o rises, ack_o stays high for max(d+1, MIN_W) clocks.
- R5: When a complete transfer ends, done_o rises one clock after ack_o falls. busy_o reads 0 whenever done_o is 1.
- R6: done_o falls on the same clock as the start_o pulse for the next accepted request.
- R7: When pause_en_i is 1, seg_done_i during a transfer drops ack_o without raising done_o, and busy_o stays 1. The next request rise resumes the channel: start_o pulses and ack_o rises again.
- R8: When pause_en_i is 0, seg_done_i has no effect, and ack_o stays high.
- R9: A request rise while ack_o is high sets err_o. It does not start a new transfer.
- R10: A request fall after acceptance but before ack_o rises sets err_o.
- R11: err_o is sticky. err_clr_i high on a clock clears it. A new illegal event on the same clock takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ext_req_i | input | 1 | External request, asynchronous |
| pause_en_i | input | 1 | Enables pause-and-resume mode |
| xfer_done_i | input | 1 | Engine reports the whole transfer finished |
| seg_done_i | input | 1 | Engine reports a segment finished (pause point) |
| err_clr_i | input | 1 | Write-one-to-clear strobe for err_o |
| start_o | output | 1 | One-clock pulse that sets the channel-start bit |
| ack_o | output | 1 | Acknowledge: transfer in progress |
| done_o | output | 1 | Transfer complete |
| busy_o | output | 1 | Channel-busy status |
| err_o | output | 1 | Sticky illegal-request-timing flag |

## Verification
A request change applied just after a clock edge produces start_o three clocks later and ack_o four clocks later. A request edge that is illegal sets err_o three clocks after the input change for a rise during a transfer (R9). For a fall before acknowledge (R10), err_o is set four clocks after the original rise. An engine report sampled at an edge drops ack_o at that same edge once the minimum width has been met, and done_o follows one clock later. The bench drives inputs one nanosecond after a rising edge and steps a counted number of edges before each sample. The ack_o high time for each table row is measured by counting samples and compared against max(d+1, 4).

// File: rtl/xreq_pkg.sv
package xreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ACK,
        ST_ACTIVE,
        ST_PAUSED,
        ST_DONE
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      ack;
        logic      done;
        logic      start;
        logic      err;
        logic      fin_pend;
        logic      pse_pend;
    } hs_regs_t;

endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xreq_edge.sv
module xreq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/xreq_width_timer.sv
module xreq_width_timer #(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic ready_o
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_W);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (toggle_i)          cnt_d = CW'(1);
        else if (cnt_q < LIMIT) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LIMIT;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/dma_xreq_handshake.sv
module dma_xreq_handshake
    import xreq_pkg::*;
#(
    parameter int MIN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_i,
    input  logic pause_en_i,
    input  logic xfer_done_i,
    input  logic seg_done_i,
    input  logic err_clr_i,
    output logic start_o,
    output logic ack_o,
    output logic done_o,
    output logic busy_o,
    output logic err_o
);
    hs_regs_t r_d, r_q;
    logic     req_s, req_rise, req_fall, width_ok, err_set, fin_now, pse_now;

    xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_req_i),
        .sync_o (req_s)
    );

    xreq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (req_s),
        .rise_o(req_rise),
        .fall_o(req_fall)
    );

    xreq_width_timer #(.MIN_W(MIN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggle_i(r_d.ack != r_q.ack),
        .ready_o (width_ok)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        err_set   = 1'b0;
        fin_now   = r_q.fin_pend | xfer_done_i;
        pse_now   = r_q.pse_pend | (pause_en_i & seg_done_i);

        case (r_q.st)
            ST_IDLE, ST_DONE, ST_PAUSED: begin
                if (req_rise) begin
                    r_d.st    = ST_WAIT_ACK;
                    r_d.start = 1'b1;
                    r_d.done  = 1'b0;
                end else if (r_q.st == ST_DONE) begin
                    r_d.done = 1'b1;
                end
            end
            ST_WAIT_ACK: begin
                if (req_fall) err_set = 1'b1;
                if (width_ok) begin
                    r_d.ack = 1'b1;
                    r_d.st  = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (req_rise) err_set = 1'b1;
                r_d.fin_pend = fin_now;
                r_d.pse_pend = pse_now;
                if ((fin_now || pse_now) && width_ok) begin
                    r_d.ack      = 1'b0;
                    r_d.st       = fin_now ? ST_DONE : ST_PAUSED;
                    r_d.fin_pend = 1'b0;
                    r_d.pse_pend = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.err = err_set | (r_q.err & ~err_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign start_o = r_q.start;
    assign ack_o   = r_q.ack;
    assign done_o  = r_q.done;
    assign err_o   = r_q.err;
    assign busy_o  = (r_q.st == ST_WAIT_ACK) || (r_q.st == ST_ACTIVE) ||
                     (r_q.st == ST_PAUSED);
endmodule

// File: rtl/xreq_chk.sv
module xreq_chk #(
    parameter int MIN_W = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_o,
    input logic ack_o,
    input logic done_o,
    input logic busy_o,
    input logic err_o,
    input logic err_clr_i
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_W);

    logic [CW-1:0] run_q;
    logic          ack_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= LIMIT;
            ack_prev_q <= 1'b0;
        end else begin
            ack_prev_q <= ack_o;
            if (ack_o != ack_prev_q) run_q <= CW'(1);
            else if (run_q < LIMIT)  run_q <= run_q + CW'(1);
        end
    end

    // R4
    ack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != ack_prev_q) |-> (run_q >= LIMIT));

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !ack_o));

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R2
    start_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !ack_o);

    // R6
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> start_o);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !err_clr_i) |=> err_o);
endmodule

bind dma_xreq_handshake xreq_chk #(.MIN_W(MIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_o  (start_o),
    .ack_o    (ack_o),
    .done_o   (done_o),
    .busy_o   (busy_o),
    .err_o    (err_o),
    .err_clr_i(err_clr_i)
);

// File: tb/dma_xreq_handshake_test.sv
module dma_xreq_handshake_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req_i = 1'b0, pause_en_i = 1'b0, xfer_done_i = 1'b0;
    logic seg_done_i = 1'b0, err_clr_i = 1'b0;
    logic start_o, ack_o, done_o, busy_o, err_o;
    int   checks = 0, errors = 0, cyc = 0;
    bit   finished = 1'b0;

    // {engine delay d after ack rise, expected ack high clocks = max(d+1,4)}
    localparam int VEC [6][2] = '{'{0, 4}, '{1, 4}, '{3, 4}, '{4, 5}, '{5, 6}, '{8, 9}};

    always #4 clk = ~clk;

    dma_xreq_handshake uut (
        .clk(clk), .rst_n(rst_n), .ext_req_i(ext_req_i), .pause_en_i(pause_en_i),
        .xfer_done_i(xfer_done_i), .seg_done_i(seg_done_i), .err_clr_i(err_clr_i),
        .start_o(start_o), .ack_o(ack_o), .done_o(done_o), .busy_o(busy_o), .err_o(err_o)
    );

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic finish_xfer();
        xfer_done_i = 1'b1;
        step();
        xfer_done_i = 1'b0;
        step(6);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    initial begin
        int hi;
        step(3);
        check({start_o, ack_o, done_o, busy_o, err_o} == 5'b0, "R1 reset outputs",
              {start_o, ack_o, done_o, busy_o, err_o}, 0);
        rst_n = 1'b1;
        step(2);

        for (int v = 0; v < 6; v++) begin
            ext_req_i = 1'b1;
            step(3);
            check(start_o == 1'b1 && ack_o == 1'b0, "R2 start pulse", {start_o, ack_o}, 2);
            check(done_o == 1'b0 && busy_o == 1'b1, "R6 done drops on accept", {done_o, busy_o}, 1);
            step();
            check(ack_o == 1'b1 && start_o == 1'b0, "R2 ack rises", {ack_o, start_o}, 2);
            ext_req_i = 1'b0;
            hi = 1;
            for (int i = 0; i < VEC[v][0]; i++) begin
                step();
                if (ack_o) hi++;
            end
            check(ack_o == 1'b1, "R3 ack held after request fall", ack_o, 1);
            xfer_done_i = 1'b1;
            step();
            xfer_done_i = 1'b0;
            for (int g = 0; g < 40 && ack_o; g++) begin
                hi++;
                step();
            end
            check(hi == VEC[v][1], "R4 ack high width", hi, VEC[v][1]);
            check(done_o == 1'b0, "R5 done lags ack fall", done_o, 0);
            step();
            check(done_o == 1'b1 && busy_o == 1'b0, "R5 done set busy clear", {done_o, busy_o}, 2);
            step(6);
        end

        // R7 pause and resume
        pause_en_i = 1'b1;
        ext_req_i = 1'b1;
        step(4);
        ext_req_i = 1'b0;
        step(5);
        seg_done_i = 1'b1;
        step();
        seg_done_i = 1'b0;
        check(ack_o == 1'b0 && done_o == 1'b0 && busy_o == 1'b1, "R7 paused",
              {ack_o, done_o, busy_o}, 1);
        step();
        check(done_o == 1'b0, "R7 no done in pause", done_o, 0);
        step(4);
        ext_req_i = 1'b1;
        step(3);
        check(start_o == 1'b1, "R7 resume start", start_o, 1);
        step();
        check(ack_o == 1'b1, "R7 resume ack", ack_o, 1);
        ext_req_i = 1'b0;
        step(5);
        xfer_done_i = 1'b1;
        step();
        xfer_done_i = 1'b0;
        check(ack_o == 1'b0, "R7 finish after resume", ack_o, 0);
        step();
        check(done_o == 1'b1, "R7 done after resume", done_o, 1);
        pause_en_i = 1'b0;
        step(6);

        // R8 segment report ignored without pause mode
        ext_req_i = 1'b1;
        step(4);
        ext_req_i = 1'b0;
        step(5);
        seg_done_i = 1'b1;
        step();
        seg_done_i = 1'b0;
        step(3);
        check(ack_o == 1'b1 && done_o == 1'b0, "R8 seg ignored", {ack_o, done_o}, 2);
        finish_xfer();

        // R9 rise during acknowledge
        ext_req_i = 1'b1;
        step(4);
        ext_req_i = 1'b0;
        step(4);
        check(err_o == 1'b0, "R9 no error before rise", err_o, 0);
        ext_req_i = 1'b1;
        step(3);
        check(err_o == 1'b1 && start_o == 1'b0 && ack_o == 1'b1, "R9 illegal rise",
              {err_o, start_o, ack_o}, 5);
        ext_req_i = 1'b0;
        step(2);
        check(err_o == 1'b1, "R11 error sticky", err_o, 1);
        err_clr_i = 1'b1;
        step();
        err_clr_i = 1'b0;
        check(err_o == 1'b0, "R11 write one clears", err_o, 0);
        finish_xfer();

        // R10 fall before acknowledge
        ext_req_i = 1'b1;
        step();
        ext_req_i = 1'b0;
        step(3);
        check(err_o == 1'b1 && ack_o == 1'b1, "R10 early fall", {err_o, ack_o}, 3);
        finish_xfer();
        check(err_o == 1'b1 && done_o == 1'b1, "R11 error held to end", {err_o, done_o}, 3);

        summary();
    end
endmodule